// File: doc/BRIEF.md
# Bus Clock-Enable Prescaler Tree

This block derives every bus, timer, converter and tick rate of a chip from one fast root clock, with no derived clocks. Each domain's rate is carried as a one-cycle enable strobe in the root domain. A consumer clocks on the root clock and advances only in cycles where its strobe is high. Three raw source strobes arrive at the inputs: an internal RC oscillator, an external crystal and a PLL output. Static configuration fields choose the system source and set each prescaler ratio.

The system strobe feeds the AHB prescaler. That output feeds two APB prescalers. APB2 feeds the converter prescaler, and the AHB strobe also feeds an 8:1 tick divider. Each APB branch also drives a timer strobe. The timer strobe equals the APB strobe when that prescaler divides by 1, and runs at twice the APB rate otherwise. A debug output selector can route out the system strobe, one of the raw sources, or the PLL strobe halved, or it can stay silent.

Every divider counts pulses of its parent strobe, so all domains stay phase-aligned to the root. A new ratio is picked up only when the divider reaches its terminal count. Reconfiguration therefore never produces a short period or a spare pulse.

Top module: `clk_strobe_tree`

## Requirements
- R1: `sys_src` picks the system strobe: 00 internal RC, 01 external crystal, 10 PLL, 11 internal RC.
- R2: `ahb_div` codes 0000 to 0111 divide by 1. Codes 1000 to 1111 divide by 2, 4, 8, 16, 64, 128, 256 and 512, in that order. The divider emits one AHB strobe per that many system strobes.
- R3: Each of `apb1_div` and `apb2_div` divides the AHB strobe. Codes 000 to 011 divide by 1, and 100, 101, 110 and 111 divide by 2, 4, 8 and 16.
- R4: A timer strobe equals its APB strobe while that APB ratio is 1. For any other ratio it pulses twice per APB period, at the APB strobe and halfway between APB strobes, counted in AHB strobes. Every APB strobe is also a timer strobe.
- R5: `adc_div` divides the APB2 strobe. Codes 000 to 101 give 2, 4, 6, 8, 12 and 16, and 110 and 111 also give 16. A divide by 6 or 12 gives exactly one strobe per 6 or 12 APB2 strobes.
- R6: The tick strobe is the AHB strobe divided by 8.
- R7: `cko_src` codes 000 to 011 keep `cko_stb` low. 100 routes the system strobe, 101 the internal RC strobe, 110 the crystal strobe, and 111 every second PLL strobe.
- R8: Each divided strobe is high only in cycles where its parent strobe is high.
- R9: A ratio change takes effect at that divider's next terminal count. Until then the old period runs to completion, with no shortened or extra strobe.
- R10: While `rst` is high every output is low. After reset each divider strobes on the first parent strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | root clock |
| rst | input | 1 | synchronous active-high reset |
| irc_stb | input | 1 | internal RC oscillator strobe |
| hxt_stb | input | 1 | external crystal strobe |
| pll_stb | input | 1 | PLL output strobe |
| sys_src | input | 2 | system source select |
| ahb_div | input | 4 | AHB ratio code |
| apb1_div | input | 3 | APB1 ratio code |
| apb2_div | input | 3 | APB2 ratio code |
| adc_div | input | 3 | converter ratio code |
| cko_src | input | 3 | debug output select |
| sys_stb | output | 1 | system strobe |
| ahb_stb | output | 1 | AHB strobe |
| apb1_stb | output | 1 | APB1 strobe |
| apb2_stb | output | 1 | APB2 strobe |
| tim1_stb | output | 1 | APB1-side timer strobe |
| tim2_stb | output | 1 | APB2-side timer strobe |
| adc_stb | output | 1 | converter strobe |
| tick_stb | output | 1 | tick reference strobe |
| cko_stb | output | 1 | debug output strobe |

## Verification
A divider count that is off by one moves its domain's strobe to the wrong parent pulse. The per-cycle comparison reports it at that divider's next terminal count, which is at most one full period (up to 512 parent strobes) after the fault. A ratio latched at the wrong moment also shows within that period, as a short or doubled interval across a configuration change. A wrong halfway point in a timer branch shows as a misplaced timer strobe inside the first APB period after the ratio is loaded.

// File: rtl/clk_tree_pkg.sv
package clk_tree_pkg;

    localparam int RATIO_W = 10;

    typedef logic [RATIO_W-1:0] ratio_t;

    typedef enum logic [1:0] {
        SRC_IRC = 2'b00,
        SRC_HXT = 2'b01,
        SRC_PLL = 2'b10,
        SRC_ALT = 2'b11
    } sys_src_e;

    typedef enum logic [2:0] {
        CKO_SYS  = 3'b100,
        CKO_IRC  = 3'b101,
        CKO_HXT  = 3'b110,
        CKO_PLL2 = 3'b111
    } cko_src_e;

    typedef struct packed {
        logic irc;
        logic hxt;
        logic pll;
    } src_strb_t;

    function automatic ratio_t ahb_ratio(input logic [3:0] code);
        ratio_t r;
        if (!code[3]) begin
            r = ratio_t'(1);
        end else if (!code[2]) begin
            r = ratio_t'(2) << code[1:0];
        end else begin
            r = ratio_t'(64) << code[1:0];
        end
        return r;
    endfunction

    function automatic ratio_t apb_ratio(input logic [2:0] code);
        ratio_t r;
        if (!code[2]) r = ratio_t'(1);
        else          r = ratio_t'(2) << code[1:0];
        return r;
    endfunction

    function automatic ratio_t adc_ratio(input logic [2:0] code);
        ratio_t r;
        case (code)
            3'd0:    r = ratio_t'(2);
            3'd1:    r = ratio_t'(4);
            3'd2:    r = ratio_t'(6);
            3'd3:    r = ratio_t'(8);
            3'd4:    r = ratio_t'(12);
            default: r = ratio_t'(16);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/strobe_divider.sv
module strobe_divider #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         par_en,
    input  logic [W-1:0] ratio,
    output logic         out_en,
    output logic         dbl_en
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] half_q;
    logic         term;

    assign term   = (cnt_q == '0);
    assign out_en = par_en && term;
    assign dbl_en = par_en && (term || (cnt_q == half_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            half_q <= '0;
        end else if (par_en) begin
            if (term) begin
                cnt_q  <= ratio - W'(1);
                half_q <= ratio >> 1;
            end else begin
                cnt_q  <= cnt_q - W'(1);
            end
        end
    end
endmodule

// File: rtl/src_mux.sv
module src_mux
    import clk_tree_pkg::*;
(
    input  src_strb_t  srcs,
    input  logic [1:0] sys_src,
    input  logic [2:0] cko_src,
    input  logic       pll_half,
    output logic       sys_raw,
    output logic       cko_raw
);
    always_comb begin
        case (sys_src_e'(sys_src))
            SRC_HXT: sys_raw = srcs.hxt;
            SRC_PLL: sys_raw = srcs.pll;
            default: sys_raw = srcs.irc;
        endcase
    end

    always_comb begin
        if (!cko_src[2]) begin
            cko_raw = 1'b0;
        end else begin
            case (cko_src_e'(cko_src))
                CKO_SYS:  cko_raw = sys_raw;
                CKO_IRC:  cko_raw = srcs.irc;
                CKO_HXT:  cko_raw = srcs.hxt;
                default:  cko_raw = pll_half;
            endcase
        end
    end
endmodule

// File: rtl/clk_strobe_tree.sv
module clk_strobe_tree
    import clk_tree_pkg::*;
#(
    parameter int RW       = RATIO_W,
    parameter int TICK_DIV = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       irc_stb,
    input  logic       hxt_stb,
    input  logic       pll_stb,
    input  logic [1:0] sys_src,
    input  logic [3:0] ahb_div,
    input  logic [2:0] apb1_div,
    input  logic [2:0] apb2_div,
    input  logic [2:0] adc_div,
    input  logic [2:0] cko_src,
    output logic       sys_stb,
    output logic       ahb_stb,
    output logic       apb1_stb,
    output logic       apb2_stb,
    output logic       tim1_stb,
    output logic       tim2_stb,
    output logic       adc_stb,
    output logic       tick_stb,
    output logic       cko_stb
);
    localparam int NAPB = 2;

    src_strb_t            srcs;
    logic                 sys_raw, cko_raw, pll_half, pll_half_dbl;
    logic                 ahb_raw, ahb_dbl_unused;
    logic                 adc_raw, adc_dbl_unused;
    logic                 tick_raw, tick_dbl_unused;
    logic [NAPB-1:0][2:0] apb_code;
    logic [NAPB-1:0]      apb_raw, tim_raw;

    assign srcs     = '{irc: irc_stb, hxt: hxt_stb, pll: pll_stb};
    assign apb_code = {apb2_div, apb1_div};

    src_mux u_mux (
        .srcs     (srcs),
        .sys_src  (sys_src),
        .cko_src  (cko_src),
        .pll_half (pll_half),
        .sys_raw  (sys_raw),
        .cko_raw  (cko_raw)
    );

    strobe_divider #(.W(RW)) u_pll2 (
        .clk(clk), .rst(rst), .par_en(pll_stb), .ratio(RW'(2)),
        .out_en(pll_half), .dbl_en(pll_half_dbl)
    );

    strobe_divider #(.W(RW)) u_ahb (
        .clk(clk), .rst(rst), .par_en(sys_raw), .ratio(RW'(ahb_ratio(ahb_div))),
        .out_en(ahb_raw), .dbl_en(ahb_dbl_unused)
    );

    for (genvar g = 0; g < NAPB; g++) begin : g_apb
        strobe_divider #(.W(RW)) u_apb (
            .clk(clk), .rst(rst), .par_en(ahb_raw),
            .ratio(RW'(apb_ratio(apb_code[g]))),
            .out_en(apb_raw[g]), .dbl_en(tim_raw[g])
        );
    end

    strobe_divider #(.W(RW)) u_adc (
        .clk(clk), .rst(rst), .par_en(apb_raw[1]), .ratio(RW'(adc_ratio(adc_div))),
        .out_en(adc_raw), .dbl_en(adc_dbl_unused)
    );

    strobe_divider #(.W(RW)) u_tick (
        .clk(clk), .rst(rst), .par_en(ahb_raw), .ratio(RW'(TICK_DIV)),
        .out_en(tick_raw), .dbl_en(tick_dbl_unused)
    );

    always_comb begin
        sys_stb  = sys_raw    && !rst;
        ahb_stb  = ahb_raw    && !rst;
        apb1_stb = apb_raw[0] && !rst;
        apb2_stb = apb_raw[1] && !rst;
        tim1_stb = tim_raw[0] && !rst;
        tim2_stb = tim_raw[1] && !rst;
        adc_stb  = adc_raw    && !rst;
        tick_stb = tick_raw   && !rst;
        cko_stb  = cko_raw    && !rst;
    end
endmodule

// File: rtl/clk_strobe_tree_chk.sv
module clk_strobe_tree_chk (
    input logic       clk,
    input logic       rst,
    input logic       irc_stb,
    input logic       hxt_stb,
    input logic       pll_stb,
    input logic [1:0] sys_src,
    input logic [3:0] ahb_div,
    input logic [2:0] apb1_div,
    input logic [2:0] apb2_div,
    input logic [2:0] adc_div,
    input logic [2:0] cko_src,
    input logic       sys_stb,
    input logic       ahb_stb,
    input logic       apb1_stb,
    input logic       apb2_stb,
    input logic       tim1_stb,
    input logic       tim2_stb,
    input logic       adc_stb,
    input logic       tick_stb,
    input logic       cko_stb
);
    // R1
    sys_irc_pick_chk: assert property (@(posedge clk) disable iff (rst)
        (sys_src == 2'b00) |-> (sys_stb == irc_stb));

    // R8
    ahb_under_sys_chk: assert property (@(posedge clk) disable iff (rst)
        ahb_stb |-> sys_stb);

    // R8
    apb1_under_ahb_chk: assert property (@(posedge clk) disable iff (rst)
        apb1_stb |-> ahb_stb);

    // R8
    apb2_under_ahb_chk: assert property (@(posedge clk) disable iff (rst)
        apb2_stb |-> ahb_stb);

    // R5
    adc_under_apb2_chk: assert property (@(posedge clk) disable iff (rst)
        adc_stb |-> apb2_stb);

    // R6
    tick_under_ahb_chk: assert property (@(posedge clk) disable iff (rst)
        tick_stb |-> ahb_stb);

    // R4
    tim1_covers_apb1_chk: assert property (@(posedge clk) disable iff (rst)
        apb1_stb |-> (tim1_stb && ahb_stb));

    // R4
    tim2_covers_apb2_chk: assert property (@(posedge clk) disable iff (rst)
        apb2_stb |-> (tim2_stb && ahb_stb));

    // R7
    cko_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !cko_src[2] |-> !cko_stb);

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        rst |-> !(sys_stb || ahb_stb || apb1_stb || apb2_stb || tim1_stb ||
                  tim2_stb || adc_stb || tick_stb || cko_stb));
endmodule

bind clk_strobe_tree clk_strobe_tree_chk u_chk (.*);

// File: tb/sim_clk_strobe_tree.sv
module sim_clk_strobe_tree;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic irc_stb = 0, hxt_stb = 0, pll_stb = 0;
    logic [1:0] sys_src = 0;
    logic [3:0] ahb_div = 0;
    logic [2:0] apb1_div = 0, apb2_div = 0, adc_div = 0, cko_src = 0;
    logic sys_stb, ahb_stb, apb1_stb, apb2_stb, tim1_stb, tim2_stb;
    logic adc_stb, tick_stb, cko_stb;

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit pll_dense = 1;

    always #5 clk = ~clk;

    clk_strobe_tree u0 (.*);

    // model state: 0 ahb, 1 apb1, 2 apb2, 3 adc, 4 tick, 5 pll/2
    int gap [6];
    int per [6];

    function automatic int m_ahb(input logic [3:0] c);
        int t [8] = '{2, 4, 8, 16, 64, 128, 256, 512};
        if (c < 8) return 1;
        return t[c - 8];
    endfunction

    function automatic int m_apb(input logic [2:0] c);
        if (c < 4) return 1;
        return 2 ** (c - 3);
    endfunction

    function automatic int m_adc(input logic [2:0] c);
        int t [6] = '{2, 4, 6, 8, 12, 16};
        if (c > 5) return 16;
        return t[c];
    endfunction

    function automatic void mstep(input int i, input bit par, input int r,
                                  output bit o, output bit h);
        o = 0;
        h = 0;
        if (par) begin
            gap[i]++;
            if (gap[i] >= per[i]) begin
                o = 1;
                gap[i] = 0;
                per[i] = r;
            end else begin
                h = (per[i] >= 2) && (gap[i] == per[i] / 2);
            end
        end
    endfunction

    task automatic chk(input string req, input string what, input bit act, input bit exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        bit e_sys, e_ahb, e_a1, e_a2, e_t1, e_t2, e_adc, e_tick, e_cko, e_p2;
        bit h0, h1, h2, h3, h4, h5;
        if (!done) begin
            if (rst) begin
                for (int i = 0; i < 6; i++) begin gap[i] = 0; per[i] = 1; end
                chk("R10", "sys in reset", sys_stb, 0);
                chk("R10", "ahb in reset", ahb_stb, 0);
                chk("R10", "apb1 in reset", apb1_stb, 0);
                chk("R10", "tim2 in reset", tim2_stb, 0);
                chk("R10", "adc in reset", adc_stb, 0);
                chk("R10", "cko in reset", cko_stb, 0);
            end else begin
                e_sys = (sys_src == 2'd1) ? hxt_stb : (sys_src == 2'd2) ? pll_stb : irc_stb;
                mstep(0, e_sys, m_ahb(ahb_div), e_ahb, h0);
                mstep(1, e_ahb, m_apb(apb1_div), e_a1, h1);
                mstep(2, e_ahb, m_apb(apb2_div), e_a2, h2);
                mstep(3, e_a2, m_adc(adc_div), e_adc, h3);
                mstep(4, e_ahb, 8, e_tick, h4);
                mstep(5, pll_stb, 2, e_p2, h5);
                e_t1 = e_a1 || h1;
                e_t2 = e_a2 || h2;
                case (cko_src)
                    3'd4:    e_cko = e_sys;
                    3'd5:    e_cko = irc_stb;
                    3'd6:    e_cko = hxt_stb;
                    3'd7:    e_cko = e_p2;
                    default: e_cko = 0;
                endcase
                chk("R1", "sys", sys_stb, e_sys);
                chk("R2/R9", "ahb", ahb_stb, e_ahb);
                chk("R3/R9", "apb1", apb1_stb, e_a1);
                chk("R3/R9", "apb2", apb2_stb, e_a2);
                chk("R4", "tim1", tim1_stb, e_t1);
                chk("R4", "tim2", tim2_stb, e_t2);
                chk("R5/R9", "adc", adc_stb, e_adc);
                chk("R6", "tick", tick_stb, e_tick);
                chk("R7", "cko", cko_stb, e_cko);
                chk("R8", "ahb within sys", ahb_stb && !sys_stb, 0);
                chk("R8", "adc within apb2", adc_stb && !apb2_stb, 0);
            end
        end
    end

    task automatic run(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
            irc_stb = ($urandom % 3) == 0;
            hxt_stb = ($urandom % 2) == 0;
            pll_stb = pll_dense ? 1'b1 : (($urandom % 4) != 0);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        cko_src = 3'd4;
        run(4);
        rst = 0;
        // R1: each system source
        for (int s = 0; s < 4; s++) begin sys_src = 2'(s); run(300); end
        // R2: every AHB code from the PLL source
        sys_src = 2'd2;
        for (int c = 0; c < 16; c++) begin ahb_div = 4'(c); run(1200); end
        // R3/R4: APB pairs
        ahb_div = 4'b1000;
        for (int c = 0; c < 8; c++) begin
            apb1_div = 3'(c); apb2_div = 3'(7 - c); run(400);
        end
        // R5: converter ratios
        apb2_div = 3'b100;
        for (int c = 0; c < 8; c++) begin adc_div = 3'(c); run(400); end
        // R7: debug output select
        pll_dense = 0;
        for (int c = 0; c < 8; c++) begin cko_src = 3'(c); run(200); end
        // R10: reset in mid-run
        rst = 1; run(3); rst = 0;
        // R9: reconfiguration at random moments
        for (int k = 0; k < 250; k++) begin
            sys_src  = 2'($urandom % 4);
            ahb_div  = ($urandom % 3 == 0) ? 4'($urandom % 16) : 4'($urandom % 4 + 8);
            apb1_div = 3'($urandom % 8);
            apb2_div = 3'($urandom % 8);
            adc_div  = 3'($urandom % 8);
            cko_src  = 3'($urandom % 8);
            pll_dense = ($urandom % 2) == 0;
            run(1 + $urandom % 50);
        end
        finish_run();
    end
endmodule